// File: doc/BRIEF.md
# Byte-Wide Converter Register Port

This block is the host-facing register front end of a data converter. A host on an 8-bit parallel bus reaches every internal register through one write strobe and one read strobe. Each write is a 16-bit word sent as two bus writes. The top two bits of the assembled word choose the destination, and the low 14 bits are stored there. Reads also move 16-bit values as two bytes. The source of a read is not given with the read itself. It comes from a sticky selector field that lives in the control register.

The block holds the control word, a test word and a bank of calibration words. The bank has eight DAC trim words plus one gain word and one offset word. A group-select field in the control word picks which slice of the bank is open, and an internal pointer walks through that slice one full access at a time. The conversion result and the converter status come from outside on input ports. The control word is driven out to the rest of the converter.

With no writes at all, the block returns conversion results. The host can then treat it as a read-only converter port.

Top module: `cvt_reg_port`

## Requirements
- R1: A word is assembled from two consecutive write strobes, with the first byte giving bits 7:0 and the second giving bits 15:8. Bus line 0 is the least significant bit of each byte. Nothing is stored until the second byte arrives.
- R2: A word whose bits 15:14 are 11 stores its bits 13:0 into the control register, and `ctrl_word` shows the new value after that write.
- R3: A word whose bits 15:14 are 00 is discarded. The control, test and calibration contents all stay unchanged.
- R4: A word whose bits 15:14 are 01 stores bits 13:0 in the test register. With read selector 01, a read returns {2'b00, test}.
- R5: Control bits 7:6 form the read selector. When it is 00, a read returns the 12-bit conversion input with four zero bits above it.
- R6: The read selector keeps its value until a new control write changes it. With selector 11, a read returns `conv_status` unchanged.
- R7: Control bits 5:4 select a calibration group. The physical order of the bank is gain, offset, dac0..dac7. The groups are:
  - 00: all ten words, starting at gain.
  - 01: gain, then offset.
  - 10: offset only.
  - 11: gain only.
  A word whose bits 15:14 are 10 goes to the word under the group pointer. The pointer advances after each complete calibration write or two-byte calibration read, and wraps at the end of the group.
- R8: Every control write returns the calibration pointer to the first word of the group.
- R9: With read selector 10, a read returns the pointed calibration word as {2'b00, value}, low byte first and high byte second.
- R10: Reads and writes keep separate byte phases. A control write that changes the read selector clears the read phase, so the next read starts again at the low byte.
- R11: After reset, the control, test and calibration registers are zero, both byte phases expect a low byte, and the read selector is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle write strobe, one per byte |
| rd_stb | input | 1 | One-cycle read strobe, one per byte; advances the read phase |
| bus_wdata | input | BUS_W | Write byte |
| bus_rdata | output | BUS_W | Read byte for the current read phase; valid in the strobe cycle |
| conv_data | input | DATA_W | Latest conversion result |
| conv_status | input | 2*BUS_W | Converter status word |
| ctrl_word | output | 2*BUS_W-2 | Stored control register |

## Verification
The bench first applies directed patterns:
- a known word whose two bytes differ, which separates low-first from high-first assembly;
- a null-address write with all data bits set, which exposes any leak into a register;
- a single-byte read followed by a selector change, which shows whether the phase realigns;
- full walks of each calibration group, which separate the wrap points and the physical ordering.

After these, seeded random writes to all four addresses are mixed with full and half reads from every source while the conversion and status inputs change. A reference model in the bench predicts every byte, so pointer, phase or mux slips show up as mismatches.

// File: rtl/cvt_reg_pkg.sv
package cvt_reg_pkg;

   typedef enum logic [1:0] {
      ADR_NONE = 2'b00,
      ADR_TEST = 2'b01,
      ADR_CAL  = 2'b10,
      ADR_CTRL = 2'b11
   } wr_addr_e;

   typedef enum logic [1:0] {
      RS_CONV = 2'b00,
      RS_TEST = 2'b01,
      RS_CAL  = 2'b10,
      RS_STAT = 2'b11
   } rd_sel_e;

   // control field positions
   localparam int RSEL_LSB = 6;
   localparam int CSEL_LSB = 4;

endpackage

// File: rtl/cvt_wr_assembler.sv
module cvt_wr_assembler #(
   parameter int BUS_W = 8,
   localparam int WORD_W = 2 * BUS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [BUS_W-1:0]  wdata,
   output logic              word_vld,
   output logic [WORD_W-1:0] word
);

   logic             ph_q;
   logic [BUS_W-1:0] lo_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q <= 1'b0;
         lo_q <= '0;
      end else if (wr_stb) begin
         if (!ph_q) lo_q <= wdata;
         ph_q <= ~ph_q;
      end
   end

   assign word_vld = wr_stb & ph_q;
   assign word     = {wdata, lo_q};

   // R1: a low byte arms the high-byte phase
   assert_low_arms_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !ph_q) |=> ph_q);

   // R1: a completed word returns the phase to low
   assert_commit_rearms_R1: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |=> !ph_q);

endmodule

// File: rtl/cvt_cal_bank.sv
module cvt_cal_bank #(
   parameter int FIELD_W = 14,
   parameter int DAC_N   = 8,
   localparam int NREG   = DAC_N + 2,
   localparam int IDX_W  = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         grp,
   input  logic               idx_clr,
   input  logic               wr_en,
   input  logic [FIELD_W-1:0] wdata,
   input  logic               step,
   output logic [FIELD_W-1:0] rdata
);

   if (DAC_N < 1) begin : g_bad_dac
      $error("cvt_cal_bank: DAC_N must be at least 1");
   end

   logic [IDX_W-1:0]   idx_q;
   logic [IDX_W-1:0]   start;
   logic [IDX_W:0]     len;
   logic [IDX_W-1:0]   phys;
   logic [IDX_W-1:0]   idx_nxt;
   logic [FIELD_W-1:0] regs [NREG];

   // group slices over physical order gain, offset, dac0..
   always_comb begin
      unique case (grp)
         2'b00:   begin start = '0;           len = (IDX_W+1)'(NREG); end
         2'b01:   begin start = '0;           len = (IDX_W+1)'(2);    end
         2'b10:   begin start = IDX_W'(1);    len = (IDX_W+1)'(1);    end
         default: begin start = '0;           len = (IDX_W+1)'(1);    end
      endcase
   end

   assign phys    = start + idx_q;
   assign idx_nxt = ({1'b0, idx_q} + 1'b1 == len) ? '0 : idx_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n)                idx_q <= '0;
      else if (idx_clr)          idx_q <= '0;
      else if (wr_en || step)    idx_q <= idx_nxt;
   end

   for (genvar k = 0; k < NREG; k++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)                                   regs[k] <= '0;
         else if (wr_en && phys == IDX_W'(k))          regs[k] <= wdata;
      end
   end

   assign rdata = regs[phys];

   // R7: the pointer never leaves the open group
   assert_idx_in_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, idx_q} < len));

   // R8: a control write parks the pointer on the first word
   assert_idx_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      idx_clr |=> (idx_q == '0));

endmodule

// File: rtl/cvt_rd_mux.sv
module cvt_rd_mux
   import cvt_reg_pkg::*;
#(
   parameter int BUS_W   = 8,
   parameter int DATA_W  = 12,
   localparam int WORD_W  = 2 * BUS_W,
   localparam int FIELD_W = WORD_W - 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_stb,
   input  logic [1:0]         sel,
   input  logic               ph_clr,
   input  logic [DATA_W-1:0]  conv,
   input  logic [WORD_W-1:0]  stat,
   input  logic [FIELD_W-1:0] test,
   input  logic [FIELD_W-1:0] cal,
   output logic [BUS_W-1:0]   rdata,
   output logic               cal_step
);

   logic              ph_q;
   logic [WORD_W-1:0] word;

   always_comb begin
      unique case (rd_sel_e'(sel))
         RS_CONV: word = {{(WORD_W-DATA_W){1'b0}}, conv};
         RS_TEST: word = {2'b00, test};
         RS_CAL:  word = {2'b00, cal};
         default: word = stat;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      ph_q <= 1'b0;
      else if (ph_clr) ph_q <= 1'b0;
      else if (rd_stb) ph_q <= ~ph_q;
   end

   assign rdata    = ph_q ? word[WORD_W-1:BUS_W] : word[BUS_W-1:0];
   assign cal_step = rd_stb & ph_q & (rd_sel_e'(sel) == RS_CAL) & ~ph_clr;

   // R5: high byte of a conversion read carries zero padding
   assert_conv_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q && rd_sel_e'(sel) == RS_CONV) |-> (rdata[BUS_W-1:DATA_W-BUS_W] == '0));

   // R10: a selector change realigns the read phase
   assert_rd_realign_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ph_clr |=> !ph_q);

endmodule

// File: rtl/cvt_reg_port.sv
module cvt_reg_port
   import cvt_reg_pkg::*;
#(
   parameter int BUS_W  = 8,
   parameter int DATA_W = 12,
   parameter int DAC_N  = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_stb,
   input  logic                  rd_stb,
   input  logic [BUS_W-1:0]      bus_wdata,
   output logic [BUS_W-1:0]      bus_rdata,
   input  logic [DATA_W-1:0]     conv_data,
   input  logic [2*BUS_W-1:0]    conv_status,
   output logic [2*BUS_W-3:0]    ctrl_word
);

   localparam int WORD_W  = 2 * BUS_W;
   localparam int FIELD_W = WORD_W - 2;

   if (BUS_W < 5) begin : g_bad_bus
      $error("cvt_reg_port: BUS_W too small for the control fields");
   end
   if (DATA_W <= BUS_W || DATA_W >= WORD_W) begin : g_bad_data
      $error("cvt_reg_port: DATA_W must lie between BUS_W and 2*BUS_W");
   end

   logic               word_vld;
   logic [WORD_W-1:0]  word;
   wr_addr_e           addr;
   logic               ctrl_we, test_we, cal_we;
   logic [FIELD_W-1:0] ctrl_q, test_q, cal_rd;
   logic [1:0]         rsel, new_rsel;
   logic               rsel_chg;
   logic               cal_step;

   cvt_wr_assembler #(.BUS_W(BUS_W)) u_wr (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wdata(bus_wdata),
      .word_vld(word_vld), .word(word)
   );

   assign addr     = wr_addr_e'(word[WORD_W-1 -: 2]);
   assign ctrl_we  = word_vld && addr == ADR_CTRL;
   assign test_we  = word_vld && addr == ADR_TEST;
   assign cal_we   = word_vld && addr == ADR_CAL;
   assign rsel     = ctrl_q[RSEL_LSB +: 2];
   assign new_rsel = word[RSEL_LSB +: 2];
   assign rsel_chg = ctrl_we && new_rsel != rsel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         test_q <= '0;
      end else begin
         if (ctrl_we) ctrl_q <= word[FIELD_W-1:0];
         if (test_we) test_q <= word[FIELD_W-1:0];
      end
   end

   cvt_cal_bank #(.FIELD_W(FIELD_W), .DAC_N(DAC_N)) u_cal (
      .clk(clk), .rst_n(rst_n), .grp(ctrl_q[CSEL_LSB +: 2]),
      .idx_clr(ctrl_we), .wr_en(cal_we), .wdata(word[FIELD_W-1:0]),
      .step(cal_step), .rdata(cal_rd)
   );

   cvt_rd_mux #(.BUS_W(BUS_W), .DATA_W(DATA_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .sel(rsel),
      .ph_clr(rsel_chg), .conv(conv_data), .stat(conv_status),
      .test(test_q), .cal(cal_rd), .rdata(bus_rdata), .cal_step(cal_step)
   );

   assign ctrl_word = ctrl_q;

   // R3: a null-address word leaves control and test untouched
   assert_null_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && addr == ADR_NONE) |=> ($stable(ctrl_q) && $stable(test_q)));

   // R6: the read selector only moves on a control write
   assert_rsel_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_we |=> $stable(ctrl_q[RSEL_LSB +: 2]));

   // R2: a control write lands in the control register
   assert_ctrl_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we |=> (ctrl_word == $past(word[FIELD_W-1:0])));

endmodule

// File: tb/cvt_reg_port_bench.sv
module cvt_reg_port_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NCAL       = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_stb = 1'b0, rd_stb = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [11:0] conv_data = '0;
   logic [15:0] conv_status = '0;
   logic [13:0] ctrl_word;

   int checks = 0, errors = 0;
   bit finished = 0;

   logic [13:0] m_ctrl, m_test;
   logic [13:0] m_cal [NCAL];
   int          m_idx;
   bit          m_rdph;

   always #(CLK_PERIOD/2) clk = ~clk;

   cvt_reg_port u_cvt_reg_port (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_data(conv_data),
      .conv_status(conv_status), .ctrl_word(ctrl_word)
   );

   function automatic int g_start(logic [1:0] g);
      return (g == 2'b10) ? 1 : 0;
   endfunction

   function automatic int g_len(logic [1:0] g);
      case (g)
         2'b00:   return NCAL;
         2'b01:   return 2;
         default: return 1;
      endcase
   endfunction

   function automatic logic [15:0] exp_word();
      case (m_ctrl[7:6])
         2'b00:   return {4'h0, conv_data};
         2'b01:   return {2'b00, m_test};
         2'b10:   return {2'b00, m_cal[g_start(m_ctrl[5:4]) + m_idx]};
         default: return conv_status;
      endcase
   endfunction

   function automatic string src_tag();
      case (m_ctrl[7:6])
         2'b00:   return "R5";
         2'b01:   return "R4";
         2'b10:   return "R9";
         default: return "R6";
      endcase
   endfunction

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic void model_reset();
      m_ctrl = '0; m_test = '0; m_idx = 0; m_rdph = 0;
      for (int i = 0; i < NCAL; i++) m_cal[i] = '0;
   endfunction

   function automatic void model_commit(logic [15:0] w);
      case (w[15:14])
         2'b01: m_test = w[13:0];
         2'b10: begin
            m_cal[g_start(m_ctrl[5:4]) + m_idx] = w[13:0];
            m_idx = (m_idx + 1 == g_len(m_ctrl[5:4])) ? 0 : m_idx + 1;
         end
         2'b11: begin
            if (w[7:6] != m_ctrl[7:6]) m_rdph = 0;
            m_ctrl = w[13:0];
            m_idx = 0;
         end
         default: ;
      endcase
   endfunction

   task automatic wr_byte(logic [7:0] b);
      @(negedge clk);
      bus_wdata = b; wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic wr_word(logic [15:0] w);
      wr_byte(w[7:0]);
      wr_byte(w[15:8]);
      model_commit(w);
      check("R2 ctrl_word", {2'b00, ctrl_word}, {2'b00, m_ctrl});
   endtask

   task automatic rd_byte(string tag);
      logic [15:0] e;
      logic [7:0]  got;
      @(negedge clk);
      rd_stb = 1'b1;
      #2;
      e   = exp_word();
      got = bus_rdata;
      check(tag, {8'h00, got}, {8'h00, m_rdph ? e[15:8] : e[7:0]});
      if (m_rdph && m_ctrl[7:6] == 2'b10)
         m_idx = (m_idx + 1 == g_len(m_ctrl[5:4])) ? 0 : m_idx + 1;
      m_rdph = ~m_rdph;
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   task automatic rd_word(string tag);
      rd_byte(tag);
      rd_byte(tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0101));
      model_reset();
      repeat (3) @(negedge clk);
      conv_data = 12'hA5C;
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      // R11: reset state, selector 00 shows conversion low byte
      check("R11 ctrl reset", {2'b00, ctrl_word}, 16'h0000);
      check("R11 idle read byte", {8'h00, bus_rdata}, 16'h005C);
      rd_word("R5 conv after reset");

      // R11: calibration bank cleared
      wr_word(16'hC080);
      rd_word("R11 cal reset");

      // R1: byte order, test register path R4
      wr_word(16'h5234);
      wr_word(16'hC040);
      rd_byte("R1 low byte first");
      rd_byte("R1 high byte second");

      // R3: null address with every data bit set
      wr_word(16'h3FFF);
      rd_word("R3 test untouched");
      check("R3 ctrl untouched", {2'b00, ctrl_word}, 16'h0040);

      // R6: status source is sticky across reads
      wr_word(16'hC0C0);
      conv_status = 16'hBEEF;
      rd_word("R6 status");
      conv_status = 16'h1357;
      rd_word("R6 status again");

      // R10: half read then selector change realigns
      rd_byte("R10 half read");
      wr_word(16'hC000);
      conv_data = 12'hFFF;
      rd_word("R10 realigned conv");
      // R10: same-selector control write keeps the phase
      rd_byte("R10 half read again");
      wr_word(16'hC000);
      rd_byte("R10 phase kept");

      // R7: fill all ten words, then walk each group
      wr_word(16'hC080);
      for (int i = 0; i < NCAL; i++) wr_word(16'h8000 | 16'(14'h0111 * (i + 1)));
      for (int g = 0; g < 4; g++) begin
         wr_word(16'hC080 | 16'(g << 4));
         for (int i = 0; i < 12; i++) rd_word("R7 group walk");
      end
      // R8: control write mid-group returns to first word
      wr_word(16'hC080);
      rd_word("R8 walk");
      rd_word("R8 walk");
      wr_word(16'hC080);
      rd_word("R8 restart at gain");

      // mixed random traffic
      for (int n = 0; n < 400; n++) begin
         int op;
         conv_data   = 12'($urandom);
         conv_status = 16'($urandom);
         op = int'($urandom_range(0, 5));
         case (op)
            0: wr_word(16'($urandom));
            1: wr_word({2'b11, 14'($urandom)});
            2: wr_word({2'b10, 14'($urandom)});
            3: rd_byte(src_tag());
            default: rd_word(src_tag());
         endcase
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule